// File: doc/BRIEF.md
# Programmable Almost-Full / Almost-Empty Flag Unit

This block sits beside a dual-clock FIFO of DEPTH words and drives one combined warning flag. The flag is high when the FIFO is nearly empty or nearly full. It holds two 8-bit offsets: an empty-side offset X and a full-side offset Y. Both start at 64 after reset. The offsets can be loaded from the low byte of the write data while an active-low program request is held, but only between reset and the first accepted data write. While a program request is in effect, the block raises a write-inhibit output, and the FIFO core uses it to suppress storage writes.

The FIFO core supplies two occupancy counts, one as seen from the write clock and one as seen from the read clock. The full-side comparison is registered on the write clock from the write-side count. The empty-side comparison is registered on the read clock from the read-side count. Each domain therefore judges the threshold on which its own view of the count is the more pessimistic one, and the output flag is the OR of the two registered results.

Programming is run by a four-state machine on the write clock:
- OPEN: programming is allowed.
- LOAD_XY: the first program cycle has just loaded X and Y.
- LOAD_Y: one or more further consecutive program cycles have reloaded Y.
- LOCKED: a data write has been accepted.

Transitions, all on a write-clock rising edge:
- open_to_load_xy: request low and ready high.
- load_xy_to_load_y: request still low.
- load_y_hold: request still low.
- load_to_open: request released with no write.
- any_to_locked: request high with an accepted write.

LOCKED is left only by reset.

Top module: `aflag_unit`

## Requirements
- R1: While and right after the asynchronous active-low reset, the flag is high, write-inhibit is low, and both offsets equal 64.
- R2: The flag is high one read-clock edge after the read-side count is at or below X. The bench probes X and X+1 for the expected high and low values.
- R3: The flag is high one write-clock edge after the write-side count is at or above DEPTH−Y. The bench probes DEPTH−Y−1 and DEPTH−Y. When both comparisons are false the flag is low.
- R4: In state OPEN, a write-clock edge with the program request low and ready high loads din_lo into both X and Y.
- R5: Each further consecutive edge with the program request still low reloads only Y from din_lo, and X keeps its value.
- R6: wr_inhibit is high whenever the program request is low and the unit is not LOCKED. Write enables seen while inhibited do not count as a data write.
- R7: A program request made while ready is low changes no offset.
- R8: An edge with the request high, wr_en high and ready high enters LOCKED. From then until reset the program request is ignored, offsets do not change, and wr_inhibit stays low.
- R9: Any offset value from 0 to 255 is honoured, including 255 for both X and Y.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| prog_n | input | 1 | Program request, active low, sampled on wr_clk |
| wr_en | input | 1 | Decoded write enable from the FIFO core |
| wr_ready | input | 1 | FIFO input-ready (not full) |
| din_lo | input | OFS_W | Low byte of write data, offset value |
| wr_count | input | CNT_W | Occupancy seen in the write domain |
| rd_count | input | CNT_W | Occupancy seen in the read domain |
| wr_inhibit | output | 1 | Tells the core to suppress storage writes |
| aflag | output | 1 | Combined almost-full / almost-empty flag |

## Verification
A wrong offset register shows up only as a flag edge at the wrong occupancy. The bench therefore sweeps each count across both sides of every threshold right after each programming step, and a wrong offset is seen within one clock of the probing count. A state machine stuck out of LOCKED or wrongly in LOCKED shows in the same cycle as a wrong wr_inhibit level during a program request. It also shows one cycle later as a flag edge that moved after a program request that should have been ignored. Offset mix-ups, such as the second cycle rewriting X, show as the empty-side edge sitting at the second value instead of the first.

// File: rtl/aflag_pkg.sv
package aflag_pkg;
    typedef enum logic [1:0] {
        PS_OPEN    = 2'd0,
        PS_LOAD_XY = 2'd1,
        PS_LOAD_Y  = 2'd2,
        PS_LOCKED  = 2'd3
    } prog_state_t;
endpackage

// File: rtl/aflag_prog_fsm.sv
module aflag_prog_fsm
    import aflag_pkg::*;
#(
    parameter int OFS_W   = 8,
    parameter int DEF_OFS = 64
) (
    input  logic             wr_clk,
    input  logic             rst_n,
    input  logic             prog_n,
    input  logic             wr_en,
    input  logic             wr_ready,
    input  logic [OFS_W-1:0] din_lo,
    output logic [OFS_W-1:0] x_ofs,
    output logic [OFS_W-1:0] y_ofs,
    output logic             wr_inhibit,
    output logic             locked,
    output prog_state_t      state
);
    prog_state_t state_nxt;
    logic        wr_accept;

    assign wr_accept = prog_n & wr_en & wr_ready;

    // next-state decode
    always_comb begin
        state_nxt = state;
        unique case (state)
            PS_OPEN: begin
                if (!prog_n && wr_ready) state_nxt = PS_LOAD_XY;
                else if (wr_accept)      state_nxt = PS_LOCKED;
            end
            PS_LOAD_XY, PS_LOAD_Y: begin
                if (!prog_n)        state_nxt = PS_LOAD_Y;
                else if (wr_accept) state_nxt = PS_LOCKED;
                else                state_nxt = PS_OPEN;
            end
            PS_LOCKED: state_nxt = PS_LOCKED;
            default:   state_nxt = PS_OPEN;
        endcase
    end

    // state register
    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) state <= PS_OPEN;
        else        state <= state_nxt;
    end

    // offset registers, written on the transitions that load them
    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) begin
            x_ofs <= OFS_W'(DEF_OFS);
            y_ofs <= OFS_W'(DEF_OFS);
        end else if (state_nxt == PS_LOAD_XY) begin
            x_ofs <= din_lo;
            y_ofs <= din_lo;
        end else if (state_nxt == PS_LOAD_Y) begin
            y_ofs <= din_lo;
        end
    end

    assign locked     = (state == PS_LOCKED);
    assign wr_inhibit = ~prog_n & ~locked;
endmodule

// File: rtl/aflag_cmp.sv
module aflag_cmp #(
    parameter int DEPTH   = 512,
    parameter int OFS_W   = 8,
    parameter int CNT_W   = 10,
    parameter bit UPPER   = 1'b0,
    parameter bit RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic [OFS_W-1:0] offset,
    output logic             hit_q
);
    logic hit;

    generate
        if (UPPER) begin : g_full_side
            logic [CNT_W-1:0] limit;
            assign limit = CNT_W'(DEPTH) - CNT_W'(offset);
            assign hit   = (count >= limit);
        end else begin : g_empty_side
            assign hit = (count <= CNT_W'(offset));
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hit_q <= RST_VAL;
        else        hit_q <= hit;
    end
endmodule

// File: rtl/aflag_unit.sv
module aflag_unit
    import aflag_pkg::*;
#(
    parameter int  DEPTH   = 512,
    parameter int  OFS_W   = 8,
    parameter int  DEF_OFS = 64,
    localparam int CNT_W   = $clog2(DEPTH) + 1
) (
    input  logic             wr_clk,
    input  logic             rd_clk,
    input  logic             rst_n,
    input  logic             prog_n,
    input  logic             wr_en,
    input  logic             wr_ready,
    input  logic [OFS_W-1:0] din_lo,
    input  logic [CNT_W-1:0] wr_count,
    input  logic [CNT_W-1:0] rd_count,
    output logic             wr_inhibit,
    output logic             aflag
);
    logic [OFS_W-1:0] x_ofs;
    logic [OFS_W-1:0] y_ofs;
    logic             locked;
    prog_state_t      state;
    logic             full_q;
    logic             empty_q;

    aflag_prog_fsm #(.OFS_W(OFS_W), .DEF_OFS(DEF_OFS)) u_fsm (
        .wr_clk    (wr_clk),
        .rst_n     (rst_n),
        .prog_n    (prog_n),
        .wr_en     (wr_en),
        .wr_ready  (wr_ready),
        .din_lo    (din_lo),
        .x_ofs     (x_ofs),
        .y_ofs     (y_ofs),
        .wr_inhibit(wr_inhibit),
        .locked    (locked),
        .state     (state)
    );

    aflag_cmp #(.DEPTH(DEPTH), .OFS_W(OFS_W), .CNT_W(CNT_W),
                .UPPER(1'b1), .RST_VAL(1'b0)) u_full (
        .clk   (wr_clk),
        .rst_n (rst_n),
        .count (wr_count),
        .offset(y_ofs),
        .hit_q (full_q)
    );

    aflag_cmp #(.DEPTH(DEPTH), .OFS_W(OFS_W), .CNT_W(CNT_W),
                .UPPER(1'b0), .RST_VAL(1'b1)) u_empty (
        .clk   (rd_clk),
        .rst_n (rst_n),
        .count (rd_count),
        .offset(x_ofs),
        .hit_q (empty_q)
    );

    assign aflag = full_q | empty_q;
endmodule

// File: rtl/aflag_unit_chk.sv
module aflag_unit_chk
    import aflag_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int OFS_W = 8,
    parameter int CNT_W = 10
) (
    input logic             wr_clk,
    input logic             rd_clk,
    input logic             rst_n,
    input logic             prog_n,
    input logic             wr_ready,
    input logic [CNT_W-1:0] wr_count,
    input logic [CNT_W-1:0] rd_count,
    input logic [OFS_W-1:0] x_ofs,
    input logic [OFS_W-1:0] y_ofs,
    input logic             wr_inhibit,
    input logic             locked,
    input prog_state_t      state,
    input logic             aflag
);
    assert_reset_flag_R1: assert property (@(posedge wr_clk) !rst_n |-> aflag);

    assert_empty_side_R2: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (rd_count <= CNT_W'(x_ofs)) |=> aflag);

    assert_full_side_R3: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (wr_count >= (CNT_W'(DEPTH) - CNT_W'(y_ofs))) |=> aflag);

    assert_first_load_R4: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (state == PS_OPEN && !prog_n && wr_ready) |=> (x_ofs == y_ofs));

    assert_x_kept_R5: assert property (@(posedge wr_clk) disable iff (!rst_n)
        ((state == PS_LOAD_XY || state == PS_LOAD_Y) && !prog_n) |=> $stable(x_ofs));

    assert_inhibit_no_lock_R6: assert property (@(posedge wr_clk) disable iff (!rst_n)
        wr_inhibit |=> !locked);

    assert_lock_sticky_R8: assert property (@(posedge wr_clk) disable iff (!rst_n)
        locked |=> (locked && $stable(x_ofs) && $stable(y_ofs)));

    assert_lock_no_inhibit_R8: assert property (@(posedge wr_clk) disable iff (!rst_n)
        locked |-> !wr_inhibit);
endmodule

bind aflag_unit aflag_unit_chk #(.DEPTH(DEPTH), .OFS_W(OFS_W), .CNT_W(CNT_W)) u_chk (
    .wr_clk    (wr_clk),
    .rd_clk    (rd_clk),
    .rst_n     (rst_n),
    .prog_n    (prog_n),
    .wr_ready  (wr_ready),
    .wr_count  (wr_count),
    .rd_count  (rd_count),
    .x_ofs     (x_ofs),
    .y_ofs     (y_ofs),
    .wr_inhibit(wr_inhibit),
    .locked    (locked),
    .state     (state),
    .aflag     (aflag)
);

// File: tb/aflag_unit_bench.sv
module aflag_unit_bench;
    localparam int DEPTH = 512;
    localparam int CNT_W = 10;

    logic            wr_clk = 1'b0;
    logic            rd_clk = 1'b0;
    logic            rst_n  = 1'b0;
    logic            prog_n = 1'b1;
    logic            wr_en  = 1'b0;
    logic            wr_ready = 1'b1;
    logic [7:0]      din_lo = '0;
    logic [CNT_W-1:0] wr_count = '0;
    logic [CNT_W-1:0] rd_count = '0;
    logic            wr_inhibit;
    logic            aflag;

    aflag_unit u_aflag_unit (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .prog_n(prog_n),
        .wr_en(wr_en), .wr_ready(wr_ready), .din_lo(din_lo),
        .wr_count(wr_count), .rd_count(rd_count),
        .wr_inhibit(wr_inhibit), .aflag(aflag)
    );

    always #5 wr_clk = ~wr_clk;
    initial begin
        #3;
        forever begin rd_clk = 1'b1; #5; rd_clk = 1'b0; #5; end
    end

    typedef struct {
        bit    flag;
        bit    inh;
        string tag;
    } exp_t;

    exp_t q[$];
    int   total = 0;
    int   bad   = 0;
    bit   done  = 0;

    // reference model of the requirements
    int xm, ym, stm; // stm: 0 open, 1 load_xy, 2 load_y, 3 locked

    task automatic model_reset();
        xm = 64; ym = 64; stm = 0;
    endtask

    task automatic apply(input bit pn, input bit we, input bit rdy, input int d,
                         input int wc, input int rc, input string tag);
        exp_t e;
        @(posedge wr_clk); #5;
        prog_n = pn; wr_en = we; wr_ready = rdy; din_lo = 8'(d);
        wr_count = CNT_W'(wc); rd_count = CNT_W'(rc);
        e.flag = (wc >= DEPTH - ym) || (rc <= xm);
        if (stm != 3) begin
            if (!pn) begin
                if (stm == 0) begin
                    if (rdy) begin xm = d; ym = d; stm = 1; end
                end else begin
                    ym = d; stm = 2;
                end
            end else if (we && rdy) stm = 3;
            else stm = 0;
        end
        e.inh = !pn && (stm != 3);
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic do_reset();
        wait (q.size() == 0);
        @(posedge wr_clk); #5;
        rst_n = 1'b0; prog_n = 1'b1; wr_en = 1'b0; wr_ready = 1'b1;
        wr_count = '0; rd_count = '0;
        repeat (4) @(posedge wr_clk);
        #2;
        total++;
        if (aflag !== 1'b1 || wr_inhibit !== 1'b0) begin
            bad++;
            $display("FAIL R1 in reset: flag=%b inh=%b expected flag=1 inh=0", aflag, wr_inhibit);
        end
        #3; rst_n = 1'b1;
        model_reset();
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge wr_clk); #4;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                total++;
                if (aflag !== e.flag || wr_inhibit !== e.inh) begin
                    bad++;
                    $display("FAIL %s: flag=%b inh=%b expected flag=%b inh=%b",
                             e.tag, aflag, wr_inhibit, e.flag, e.inh);
                end
            end
        end
    end

    // watchdog
    initial begin
        #200000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        do_reset();
        // R1: defaults right after reset
        apply(1, 0, 1, 0, 0, 0, "R1 flag after reset");
        apply(1, 0, 1, 0, 0, 64, "R1 R2 default X=64 edge");
        apply(1, 0, 1, 0, 0, 65, "R1 R2 default X+1");
        apply(1, 0, 1, 0, 447, 300, "R1 R3 default 512-Y-1");
        apply(1, 0, 1, 0, 448, 300, "R1 R3 default 512-Y");
        apply(1, 0, 1, 0, 300, 300, "R3 mid occupancy low");
        // R4 + R5 + R6: program X=Y=20 then Y=30, write enable held high
        apply(0, 1, 1, 20, 0, 0, "R4 R6 first program cycle");
        apply(0, 1, 1, 30, 0, 0, "R5 R6 second program cycle");
        apply(1, 0, 1, 0, 0, 20, "R4 R5 X stays 20");
        apply(1, 0, 1, 0, 0, 21, "R4 R5 X+1 low");
        apply(1, 0, 1, 0, 481, 300, "R5 512-Y-1 with Y=30");
        apply(1, 0, 1, 0, 482, 300, "R5 512-Y with Y=30");
        // R6: writes during programming did not lock, reprogram allowed
        apply(0, 1, 1, 10, 0, 0, "R6 reprogram after inhibited writes");
        apply(1, 0, 1, 0, 0, 11, "R6 X=10 X+1 low");
        apply(1, 0, 1, 0, 0, 10, "R6 X=10 edge");
        apply(1, 0, 1, 0, 501, 300, "R6 Y=10 512-Y-1");
        apply(1, 0, 1, 0, 502, 300, "R6 Y=10 512-Y");
        // R7: program request with ready low is ignored
        apply(0, 0, 0, 99, 0, 11, "R7 request while not ready");
        apply(1, 0, 1, 0, 0, 11, "R7 X unchanged");
        apply(1, 0, 1, 0, 300, 99, "R7 X not 99");
        // R8: accepted write locks
        apply(1, 1, 1, 0, 1, 300, "R8 first data write");
        apply(0, 0, 1, 200, 1, 11, "R8 request ignored, no inhibit");
        apply(0, 0, 1, 250, 1, 11, "R8 second request ignored");
        apply(1, 0, 1, 0, 0, 11, "R8 X still 10");
        apply(1, 0, 1, 0, 501, 300, "R8 Y still 10");
        // R9: maximal offsets, three consecutive program cycles
        do_reset();
        apply(0, 0, 1, 255, 0, 0, "R9 program 255");
        apply(0, 0, 1, 100, 0, 0, "R5 second cycle Y=100");
        apply(0, 0, 1, 255, 0, 0, "R5 third cycle Y=255");
        apply(1, 0, 1, 0, 0, 255, "R9 X=255 edge");
        apply(1, 0, 1, 0, 0, 256, "R9 X+1 low");
        apply(1, 0, 1, 0, 256, 300, "R9 512-Y-1 low");
        apply(1, 0, 1, 0, 257, 300, "R9 512-Y high");
        // R9: zero offsets
        do_reset();
        apply(0, 0, 1, 0, 0, 5, "R9 program 0");
        apply(1, 0, 1, 0, 0, 0, "R9 X=0 empty high");
        apply(1, 0, 1, 0, 0, 1, "R9 X=0 one word low");
        apply(1, 0, 1, 0, 511, 300, "R9 Y=0 511 low");
        apply(1, 0, 1, 0, 512, 300, "R9 Y=0 512 high");
        wait (q.size() == 0);
        @(posedge wr_clk); #5;
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule